// File: doc/BRIEF.md
# PWM Cycle Run/Halt Controller

This block is a free-running PWM period counter with start and stop control. A local run bit starts the counter. The counter counts up from zero to a programmed period value and then wraps to zero. The PWM output is high while the count is below a compare value. A one-clock end-of-cycle strobe marks each wrap.

A run-follow input, driven by a partner generator, can also start and hold the counter, so two channels can run in step. The local run bit takes priority over that input. When the last run source drops, the block stops in one of two ways. It can stop at once, freezing the count and pulling the output low. Or it can let the current waveform cycle finish and stop at the wrap. The second way is chosen by a finish-cycle option. That option applies only when the local run bit was the source that held the counter running.

Top module: `pwm_runctl`

## Requirements
- R1: While stopped, a high `run_local` on a clock edge starts the block: after that edge `running` is 1 and `count` is 0.
- R2: While `run_local` is 1 the block keeps running whatever `run_follow` does. `run_follow` alone also starts the block and keeps it running.
- R3: If the block was held by `run_local`, `finish_cycle` is 1, and both run inputs drop, the block keeps counting and stays running until the end of the current cycle.
- R4: If the block was held by `run_local`, `finish_cycle` is 0, and both run inputs drop, then on the next edge `running` falls, `count` keeps its value and `pwm_out` is 0.
- R5: If the block was held by `run_follow` alone (`run_local` 0 on the previous edge) and `run_follow` drops, it stops at once as in R4, whatever the value of `finish_cycle`.
- R6: While running, `count` rises by one per clock up to `period`, then returns to 0 on the following edge.
- R7: `pwm_out` is 1 only while running and `count` < `compare`. So a compare of 0 keeps it low, and a compare above `period` keeps it high for the whole cycle.
- R8: `cycle_end` is 1 for one clock while running with `count` equal to `period`. A pending finish-cycle halt takes effect on the edge that ends that clock: `running` goes to 0 and `count` goes to 0.
- R9: A run input that rises again during a pending finish-cycle halt cancels the halt, and counting continues without a break.
- R10: While reset is active and after it is released, `running` is 0, `count` is 0, and `pwm_out` and `cycle_end` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_local | input | 1 | Local run bit |
| run_follow | input | 1 | Run request from a partner generator |
| finish_cycle | input | 1 | 1: a local stop waits for the end of the current cycle |
| period | input | CNT_W | Last count value of a cycle |
| compare | input | CNT_W | Count below which the output is high |
| pwm_out | output | 1 | PWM waveform |
| cycle_end | output | 1 | One-clock strobe on the last count of a cycle |
| running | output | 1 | High from start until the halt takes effect |
| count | output | CNT_W | Current counter value |

## Verification
A wrong record of which source holds the block shows up at the first stop: `running` falls an edge early (the block freezes when it should drain) or stays high for up to a whole period too long. A wrong pending-halt flag shows up at the next `cycle_end`: `count` returns to 0 but `running` stays high, or the block halts when a run input has come back. Counter faults show up within one period, as a missing strobe, a missing wrap to 0, or a `pwm_out` edge at the wrong count.

// File: rtl/pwm_runctl_pkg.sv
package pwm_runctl_pkg;
    // action the arbiter selects for the next clock edge
    typedef enum logic [2:0] {
        ACT_IDLE    = 3'd0,
        ACT_START   = 3'd1,
        ACT_ADVANCE = 3'd2,
        ACT_FREEZE  = 3'd3,
        ACT_HALT    = 3'd4
    } run_act_e;
endpackage

// File: rtl/pwm_run_arb.sv
module pwm_run_arb
    import pwm_runctl_pkg::*;
(
    input  logic     running_q,
    input  logic     drain_q,
    input  logic     local_q,
    input  logic     run_local,
    input  logic     run_follow,
    input  logic     finish_cycle,
    input  logic     wrap,
    output run_act_e act,
    output logic     drain_d,
    output logic     local_d
);
    logic go;

    always_comb begin
        // the local bit wins; the partner request only matters when it is clear
        go      = run_local | run_follow;
        act     = ACT_IDLE;
        drain_d = 1'b0;
        local_d = local_q;
        if (!running_q) begin
            if (go) begin
                act     = ACT_START;
                local_d = run_local;
            end
        end else if (go) begin
            act     = ACT_ADVANCE;
            local_d = run_local;
        end else if (drain_q || (local_q && finish_cycle)) begin
            act     = wrap ? ACT_HALT : ACT_ADVANCE;
            drain_d = !wrap;
        end else begin
            act = ACT_FREEZE;
        end
    end
endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             running_q,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] compare,
    output logic             wrap,
    output logic [CNT_W-1:0] cnt_next,
    output logic             pwm
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb begin
        wrap     = running_q && (cnt_q >= period);
        cnt_next = wrap ? '0 : cnt_q + ONE;
        pwm      = running_q && (cnt_q < compare);
    end
endmodule

// File: rtl/pwm_runctl.sv
module pwm_runctl
    import pwm_runctl_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_local,
    input  logic             run_follow,
    input  logic             finish_cycle,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] compare,
    output logic             pwm_out,
    output logic             cycle_end,
    output logic             running,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic             running;
        logic             drain;
        logic             local_src;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t     st_q, st_d;
    run_act_e act;
    logic     wrap, pwm_raw, drain_n, local_n;
    logic     drain_q, local_q;
    logic [CNT_W-1:0] cnt_inc;

    assign drain_q = st_q.drain;
    assign local_q = st_q.local_src;

    pwm_period_cnt #(.CNT_W(CNT_W)) u_cnt (
        .running_q (st_q.running),
        .cnt_q     (st_q.cnt),
        .period    (period),
        .compare   (compare),
        .wrap      (wrap),
        .cnt_next  (cnt_inc),
        .pwm       (pwm_raw)
    );

    pwm_run_arb u_arb (
        .running_q    (st_q.running),
        .drain_q      (st_q.drain),
        .local_q      (st_q.local_src),
        .run_local    (run_local),
        .run_follow   (run_follow),
        .finish_cycle (finish_cycle),
        .wrap         (wrap),
        .act          (act),
        .drain_d      (drain_n),
        .local_d      (local_n)
    );

    always_comb begin
        st_d           = st_q;
        st_d.local_src = local_n;
        st_d.drain     = drain_n;
        case (act)
            ACT_START: begin
                st_d.running = 1'b1;
                st_d.cnt     = '0;
            end
            ACT_ADVANCE: st_d.cnt = cnt_inc;
            ACT_FREEZE:  st_d.running = 1'b0;
            ACT_HALT: begin
                st_d.running = 1'b0;
                st_d.cnt     = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_out   = pwm_raw;
    assign cycle_end = wrap;
    assign running   = st_q.running;
    assign count     = st_q.cnt;
endmodule

// File: rtl/pwm_runctl_chk.sv
module pwm_runctl_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_local,
    input logic             run_follow,
    input logic             finish_cycle,
    input logic [CNT_W-1:0] period,
    input logic             pwm_out,
    input logic             cycle_end,
    input logic             running,
    input logic [CNT_W-1:0] count,
    input logic             drain_q,
    input logic             local_q
);
    p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && run_local) |=> (running && count == '0));

    p_local_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run_local) |=> running);

    p_drain_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && local_q && !drain_q && finish_cycle && !run_local && !run_follow && !cycle_end)
        |=> running);

    p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && local_q && !drain_q && !finish_cycle && !run_local && !run_follow)
        |=> (!running && $stable(count) && !pwm_out));

    p_follow_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !local_q && !drain_q && !run_local && !run_follow)
        |=> (!running && $stable(count)));

    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_end && (run_local || run_follow)) |=> (running && count == '0));

    p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!pwm_out && !cycle_end));

    p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_q && cycle_end && !run_local && !run_follow) |=> (!running && count == '0));

    p_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |-> (count >= period));
endmodule

bind pwm_runctl pwm_runctl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_local    (run_local),
    .run_follow   (run_follow),
    .finish_cycle (finish_cycle),
    .period       (period),
    .pwm_out      (pwm_out),
    .cycle_end    (cycle_end),
    .running      (running),
    .count        (count),
    .drain_q      (drain_q),
    .local_q      (local_q)
);

// File: tb/pwm_runctl_test.sv
module pwm_runctl_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run_local = 1'b0, run_follow = 1'b0, finish_cycle = 1'b0;
    logic [W-1:0] period = 8'd5, compare = 8'd2;
    logic         pwm_out, cycle_end, running;
    logic [W-1:0] count;

    int n_chk = 0, n_fail = 0;

    typedef struct {
        logic         run;
        logic         pwm;
        logic         cend;
        logic [W-1:0] cnt;
        string        tag;
    } exp_t;
    exp_t sb[$];

    // reference state, written from the requirements
    logic         m_run = 0, m_drain = 0, m_local = 0;
    logic [W-1:0] m_cnt = 0;

    always #4 clk = ~clk;   // 125 MHz

    pwm_runctl #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .run_local(run_local), .run_follow(run_follow),
        .finish_cycle(finish_cycle), .period(period), .compare(compare),
        .pwm_out(pwm_out), .cycle_end(cycle_end), .running(running), .count(count)
    );

    function automatic logic m_wrap();
        return m_run && (m_cnt >= period);
    endfunction

    // driver: apply inputs for one cycle and queue the expected result
    task automatic drive(input logic rl, input logic rf, input logic fc, input string tag);
        logic go, w;
        exp_t e;
        @(negedge clk);
        run_local = rl; run_follow = rf; finish_cycle = fc;
        go = rl | rf;
        w  = m_wrap();
        if (!m_run) begin
            if (go) begin m_run = 1; m_cnt = 0; m_local = rl; m_drain = 0; end
        end else if (go) begin
            m_local = rl; m_drain = 0;
            m_cnt = w ? 8'd0 : m_cnt + 8'd1;
        end else if (m_drain || (m_local && fc)) begin
            if (w) begin m_run = 0; m_cnt = 0; m_drain = 0; end
            else begin m_drain = 1; m_cnt = m_cnt + 8'd1; end
        end else begin
            m_run = 0; m_drain = 0;
        end
        e.run  = m_run;
        e.pwm  = m_run && (m_cnt < compare);
        e.cend = m_wrap();
        e.cnt  = m_cnt;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic drive_n(input int n, input logic rl, input logic rf, input logic fc, input string tag);
        for (int i = 0; i < n; i++) drive(rl, rf, fc, tag);
    endtask

    // monitor: after each edge, pop one expected item and compare
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (running !== e.run || pwm_out !== e.pwm || cycle_end !== e.cend || count !== e.cnt) begin
                n_fail++;
                $display("FAIL %s: got run=%0b pwm=%0b end=%0b cnt=%0d, expected run=%0b pwm=%0b end=%0b cnt=%0d",
                         e.tag, running, pwm_out, cycle_end, count, e.run, e.pwm, e.cend, e.cnt);
            end
        end
    end

    initial begin
        for (int i = 0; i < 5000; i++) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout, expected end of test");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        n_chk++;   // R10 during reset
        if (running !== 0 || count !== 0 || pwm_out !== 0 || cycle_end !== 0) begin
            n_fail++;
            $display("FAIL R10: got run=%0b cnt=%0d pwm=%0b end=%0b, expected 0 0 0 0",
                     running, count, pwm_out, cycle_end);
        end
        @(negedge clk); rst_n = 1'b1;
        drive_n(2, 0, 0, 0, "R10");
        // R1, R6, R7, R8: start locally, period 5, compare 2
        drive(1, 0, 0, "R1");
        drive_n(13, 1, 0, 0, "R6");
        // R3: finish-cycle stop from mid-cycle, then R8 halt at the wrap
        drive_n(8, 0, 0, 1, "R3");
        drive_n(2, 0, 0, 0, "R8");
        // R4: immediate stop freezes the count
        drive_n(3, 1, 0, 0, "R1");
        drive_n(3, 0, 0, 0, "R4");
        // R2: local bit wins while the follow input toggles
        drive(1, 1, 0, "R2");
        drive_n(3, 1, 0, 0, "R2");
        drive_n(3, 1, 1, 0, "R2");
        drive_n(2, 1, 0, 0, "R2");
        drive_n(2, 0, 0, 0, "R4");
        // R5: follow-held stop ignores the finish-cycle option
        drive_n(4, 0, 1, 1, "R5");
        drive_n(3, 0, 0, 1, "R5");
        // R9: a run input returning during a pending halt cancels it
        drive_n(3, 1, 0, 1, "R9");
        drive_n(1, 0, 0, 1, "R9");
        drive_n(8, 0, 1, 1, "R9");
        drive_n(2, 0, 0, 0, "R9");
        // R7 with compare 0 and compare above the period
        compare = 8'd0;
        drive_n(8, 1, 0, 0, "R7");
        drive_n(1, 0, 0, 0, "R7");
        compare = 8'd9;
        drive_n(8, 1, 0, 0, "R7");
        drive_n(1, 0, 0, 0, "R7");
        // R8 with period 0: strobe on every clock, halt on the first one
        period = 8'd0; compare = 8'd1;
        drive_n(4, 1, 0, 1, "R8");
        drive_n(2, 0, 0, 1, "R8");
        @(negedge clk); @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule